// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

A 16-bit combinational adder that avoids rippling carries from one bit to the next. The operands are split into four 4-bit groups. Each group forms a per-bit generate (`a & b`) and propagate (`a | b`) signal. From these it derives a group propagate, a group generate and its own internal carries, each written as a flat sum of products. A second-level lookahead unit applies the same equations to the four group signals. It produces the carry into each upper group and the final carry-out. Each sum bit is then the XOR of the two operand bits and the carry into that bit.

The block-wide propagate and generate are brought out, so a wider adder can place these 16-bit blocks under a further lookahead level. Evaluation runs in a fixed order: bit signals, then group signals, then second-level carries, then in-group carries, then sums. The logic depth therefore grows with the number of levels and not with the width.

Top module: `cla_adder16`

## Requirements
- R1: `sum_o` equals `(a_i + b_i + c_i) mod 2^16` for every input combination.
- R2: `c_o` equals bit 16 of the 17-bit sum `a_i + b_i + c_i`.
- R3: `p_o` is 1 exactly when every bit position has `a_i[k] | b_i[k]` equal to 1.
- R4: `g_o` is 1 exactly when `a_i + b_i` with zero carry-in produces a carry out of bit 15.
- R5: `c_o` equals `g_o | (p_o & c_i)`, so the block can be placed under a higher lookahead level.
- R6: when `a_i ^ b_i` is all ones, a carry-in of 1 propagates through all 16 bits: `sum_o` is 0 and `c_o` is 1.
- R7: the carry into bit 4, 8 and 12 from the second-level unit is correct. A carry generated in a lower group and propagated to a group boundary appears in the upper group's sum. Each group's own carry-out agrees with the second-level carry for the same boundary.
- R8: with all-ones operands, both `p_o` and `g_o` are 1. With all-zero operands and `c_i` equal to 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| c_o | output | 1 | Carry out of bit 15 |
| p_o | output | 1 | Block propagate |
| g_o | output | 1 | Block generate |

## Verification
The hardest situation to reach from the ports is a carry that is born in one group, crosses one or more group boundaries through long propagate runs, and is then used by the in-group carries of a distant group. Random operands rarely line up that way. The bench therefore builds operands directly: a single generating bit is placed just below a boundary and followed by propagating bits up to a chosen position. Alternating and all-ones patterns are added, along with a full-width propagate chain driven only by `c_i`. The sum bits just above each boundary then expose whether the second-level carry arrived.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned GRP_W  = 4;
  localparam int unsigned N_GRP  = 4;
  localparam int unsigned DATA_W = GRP_W * N_GRP;
endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] gen_o,
  output logic [W-1:0] prop_o
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    assign gen_o[k]  = a_i[k] & b_i[k];
    assign prop_o[k] = a_i[k] | b_i[k];
  end
endmodule

// File: rtl/cla_lookahead.sv
// Flat sum-of-products carries; carry_o[k] is the carry into position k+1.
module cla_lookahead #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] gen_i,
  input  logic [W-1:0] prop_i,
  input  logic         cin_i,
  output logic [W-1:0] carry_o,
  output logic         grp_p_o,
  output logic         grp_g_o
);
  always_comb begin
    for (int k = 0; k < W; k++) begin
      logic acc;
      logic chain;
      chain = cin_i;
      for (int m = 0; m <= k; m++) chain = chain & prop_i[m];
      acc = chain;
      for (int j = 0; j <= k; j++) begin
        logic term;
        term = gen_i[j];
        for (int m = j + 1; m <= k; m++) term = term & prop_i[m];
        acc = acc | term;
      end
      carry_o[k] = acc;
    end
  end

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int j = 0; j < W; j++) begin
      logic term;
      term = gen_i[j];
      for (int m = j + 1; m < W; m++) term = term & prop_i[m];
      acc = acc | term;
    end
    grp_g_o = acc;
    grp_p_o = &prop_i;
  end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         grp_p_o,
  output logic         grp_g_o
);
  logic [W-1:0] gen, prop, carry, cin_vec;

  cla_bit_pg #(.W(W)) u_pg (
    .a_i   (a_i),
    .b_i   (b_i),
    .gen_o (gen),
    .prop_o(prop)
  );

  cla_lookahead #(.W(W)) u_la (
    .gen_i  (gen),
    .prop_i (prop),
    .cin_i  (cin_i),
    .carry_o(carry),
    .grp_p_o(grp_p_o),
    .grp_g_o(grp_g_o)
  );

  if (W > 1) begin : g_vec
    assign cin_vec = {carry[W-2:0], cin_i};
  end else begin : g_one
    assign cin_vec = cin_i;
  end

  assign sum_o  = a_i ^ b_i ^ cin_vec;
  assign cout_o = carry[W-1];
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
  import cla_pkg::*;
#(
  parameter int unsigned GW = GRP_W,
  parameter int unsigned NG = N_GRP,
  localparam int unsigned DW = GW * NG
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          c_i,
  output logic [DW-1:0] sum_o,
  output logic          c_o,
  output logic          p_o,
  output logic          g_o
);
  logic [NG-1:0] grp_p, grp_g, grp_cout, lvl2_carry, grp_cin;

  cla_lookahead #(.W(NG)) u_lvl2 (
    .gen_i  (grp_g),
    .prop_i (grp_p),
    .cin_i  (c_i),
    .carry_o(lvl2_carry),
    .grp_p_o(p_o),
    .grp_g_o(g_o)
  );

  if (NG > 1) begin : g_cin
    assign grp_cin = {lvl2_carry[NG-2:0], c_i};
  end else begin : g_cin1
    assign grp_cin = c_i;
  end

  for (genvar q = 0; q < NG; q++) begin : g_grp
    cla_group #(.W(GW)) u_grp (
      .a_i    (a_i[q*GW +: GW]),
      .b_i    (b_i[q*GW +: GW]),
      .cin_i  (grp_cin[q]),
      .sum_o  (sum_o[q*GW +: GW]),
      .cout_o (grp_cout[q]),
      .grp_p_o(grp_p[q]),
      .grp_g_o(grp_g[q])
    );
  end

  assign c_o = lvl2_carry[NG-1];
endmodule

// File: rtl/cla_adder16_chk.sv
module cla_adder16_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned NG = 4
) (
  input logic [DW-1:0] a_i,
  input logic [DW-1:0] b_i,
  input logic          c_i,
  input logic [DW-1:0] sum_o,
  input logic          c_o,
  input logic          p_o,
  input logic          g_o,
  input logic [NG-1:0] grp_cout,
  input logic [NG-1:0] lvl2_carry
);
  logic [DW:0] ref_full, ref_nocin;
  assign ref_full  = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, c_i};
  assign ref_nocin = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    a_r1_sum_value: assert ({c_o, sum_o} == ref_full)
      else $error("R1/R2 sum mismatch");
    a_r3_block_propagate: assert (p_o == &(a_i | b_i))
      else $error("R3 propagate mismatch");
    a_r4_block_generate: assert (g_o == ref_nocin[DW])
      else $error("R4 generate mismatch");
    a_r7_group_carry_agree: assert (grp_cout == lvl2_carry)
      else $error("R7 group carry disagrees with second level");
  end
endmodule

bind cla_adder16 cla_adder16_chk #(.DW(DW), .NG(NG)) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .c_i       (c_i),
  .sum_o     (sum_o),
  .c_o       (c_o),
  .p_o       (p_o),
  .g_o       (g_o),
  .grp_cout  (grp_cout),
  .lvl2_carry(lvl2_carry)
);

// File: tb/cla_adder16_test.sv
module cla_adder16_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] a, b, sum;
  logic        cin, cout, pp, gg;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  cla_adder16 uut (
    .a_i  (a),
    .b_i  (b),
    .c_i  (cin),
    .sum_o(sum),
    .c_o  (cout),
    .p_o  (pp),
    .g_o  (gg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (a=%h b=%h c=%0b)", tag, act, exp, a, b, cin);
    end
  endtask

  task automatic apply_check(input logic [15:0] av, input logic [15:0] bv, input logic cv);
    logic [16:0] full, nocin;
    @(negedge clk);
    a = av; b = bv; cin = cv;
    #1;
    full  = {1'b0, av} + {1'b0, bv} + {16'd0, cv};
    nocin = {1'b0, av} + {1'b0, bv};
    chk("R1 sum", {16'd0, sum}, {16'd0, full[15:0]});
    chk("R2 carry", {31'd0, cout}, {31'd0, full[16]});
    chk("R3 propagate", {31'd0, pp}, {31'd0, &(av | bv)});
    chk("R4 generate", {31'd0, gg}, {31'd0, nocin[16]});
    chk("R5 cascade", {31'd0, cout}, {31'd0, gg | (pp & cv)});
  endtask

  task automatic t_zero;
    apply_check(16'h0000, 16'h0000, 1'b0);
    chk("R8 zero sum", {16'd0, sum}, 32'd0);
    chk("R8 zero p", {31'd0, pp}, 32'd0);
    chk("R8 zero g", {31'd0, gg}, 32'd0);
  endtask

  task automatic t_all_ones;
    apply_check(16'hFFFF, 16'hFFFF, 1'b0);
    chk("R8 ones p", {31'd0, pp}, 32'd1);
    chk("R8 ones g", {31'd0, gg}, 32'd1);
    apply_check(16'hFFFF, 16'hFFFF, 1'b1);
    chk("R8 ones sum", {16'd0, sum}, 32'h0000FFFF);
  endtask

  task automatic t_alternating;
    apply_check(16'hAAAA, 16'h5555, 1'b0);
    apply_check(16'hAAAA, 16'h5555, 1'b1);
    apply_check(16'hAAAA, 16'hAAAA, 1'b1);
    apply_check(16'h5555, 16'h5555, 1'b0);
    apply_check(16'h3333, 16'hCCCC, 1'b1);
  endtask

  task automatic t_long_chain;
    // R6: full propagate run driven only by the carry-in
    apply_check(16'hF0F0, 16'h0F0F, 1'b1);
    chk("R6 chain sum", {16'd0, sum}, 32'd0);
    chk("R6 chain carry", {31'd0, cout}, 32'd1);
    apply_check(16'hFFFF, 16'h0000, 1'b1);
    chk("R6 chain sum2", {16'd0, sum}, 32'd0);
    chk("R6 chain carry2", {31'd0, cout}, 32'd1);
    apply_check(16'hFFFF, 16'h0000, 1'b0);
    chk("R6 no carry", {31'd0, cout}, 32'd0);
  endtask

  task automatic t_boundary;
    // R7: generate at bit gpos, propagate through bits gpos+1..top
    for (int gpos = 0; gpos < 15; gpos++) begin
      for (int top = gpos + 1; top < 16; top++) begin
        logic [15:0] av, bv, run;
        run = 16'd0;
        for (int m = gpos + 1; m < top; m++) run[m] = 1'b1;
        av = run | (16'd1 << gpos);
        bv = 16'd1 << gpos;
        apply_check(av, bv, 1'b0);
        chk("R7 boundary bit", {31'd0, sum[top]}, 32'd1);
      end
    end
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++) begin
      apply_check(16'($urandom), 16'($urandom), 1'($urandom));
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_zero();
    t_all_ones();
    t_alternating();
    t_long_chain();
    t_boundary();
    t_random();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule